// File: doc/BRIEF.md
# Host-side UART register emulator

This block lets a local microprocessor pose as a PC-style serial port. A host bus sees the familiar eight-address UART register window: data, interrupt enable, interrupt identification and FIFO control, line control, modem control, line status, modem status and scratch. No bit is ever shifted. Each host access the processor must react to (a transmit write, a line or modem control write, a divisor write, a FIFO control write, a receive read) sets a notification flag. Each flag has its own mask bit and one global enable gates them all, so a single masked interrupt line reaches the processor. The processor then plays the UART's part through a sixteen-entry register window of its own.

The processor writes the receive byte, the error and data-ready bits of line status, the modem status and a receive-timeout flag. From these and the host's interrupt enables, the block ranks the pending host interrupt causes and presents the identification code. The processor reads back every shadow the host wrote. A transmit byte moves from the holding register into a transmit shift buffer only when that buffer is empty and a character delay timer has run out. This keeps the host from seeing the transmitter drain faster than a real line would allow.

Both ports share one clock. Host strobes are qualified by chip select and act on the rising edge. Read data on both ports is combinational from the current address.

Top module: `uart_host_shadow`

## Requirements
- R1: After reset the host reads 0x01 from the identification register (address 2) and 0x60 from line status (address 5). The processor interrupt is low, the host interrupt output enable is low, and all control shadows read 0.
- R2: While line control bit 7 is 1, host address 0 reads and writes the divisor low byte and address 1 the divisor high byte; the processor reads these at addresses 9 and 10. While the bit is 0, address 0 is the transmit holding register (write) or receive byte (read), and address 1 is the interrupt enable register.
- R3: Processor address 4 returns the notification flags. Bit 0 is a transmit holding write, bit 1 a divisor low write, bit 2 a divisor high write, bit 3 a FIFO control write, bit 4 a line control write, bit 5 a modem control write and bit 6 a receive byte read; bit 7 reads 0. Other host accesses set no flag. A processor read of address 4 clears all flags.
- R4: The processor interrupt is high exactly when bit 7 of the mask register (processor address 5) is 1 and some flag is 1 whose mask bit (same position, bits 0 to 6) is 1.
- R5: When a host access sets a flag in the same cycle as a processor read of address 4, the clear wins and the flag reads 0 afterwards.
- R6: The identification register reads 0x06 for line status, 0x04 for received data, 0x0C for receive timeout, 0x02 for transmit holding empty, 0x00 for modem status and 0x01 for none, with priority in that order from highest.
- R7: Interrupt enable bit 2 enables line status (any of line status bits 1 to 4). Bit 0 enables received data (line status bit 0) and receive timeout (processor address 13 bit 0). Bit 1 enables transmit holding empty. Bit 3 enables modem status (any of modem status bits 0 to 3).
- R8: The transmit holding empty cause becomes pending when a byte leaves the holding register. A host write of the holding register clears it, and so does a host read of address 2 that returns 0x02.
- R9: The host interrupt output enable equals modem control bit 3, and the host interrupt is high exactly while the identification code is not 0x01.
- R10: Line status bit 5 is 1 while the holding register is empty, and bit 6 while both the holding register and the shift buffer are empty. A byte moves into the shift buffer at the first clock edge at which the buffer is empty and the delay counter is 0. The transfer loads the counter from processor address 6, and a nonzero counter decrements by one on each edge.
- R11: Processor address 3 returns the shift buffer byte, and reading it empties the buffer. Processor address 15 reads {6'b0, shift buffer full, holding register full}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_cs | input | 1 | Host chip select |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 3 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| h_irq | output | 1 | Host interrupt request |
| h_irq_oe | output | 1 | Drive enable for the host interrupt pin |
| m_cs | input | 1 | Processor chip select |
| m_rd | input | 1 | Processor read strobe |
| m_wr | input | 1 | Processor write strobe |
| m_addr | input | 4 | Processor register address |
| m_wdata | input | 8 | Processor write data |
| m_rdata | output | 8 | Processor read data |
| m_irq | output | 1 | Masked notification interrupt to the processor |

## Verification
The assertions check the timing of the transmit path on every cycle. A byte can reach the shift buffer only from a zero counter, the counter reloads on that transfer, and it then steps down by one. They also check that the interrupt drive enable follows each modem control write, that a status read leaves the processor interrupt low, that a cleared global enable silences it, and that the identification code is always a legal value. The bench's scenarios are needed to show which host accesses raise which flag under each divisor-latch setting, the full priority ranking against random enables and sources, the exact edges at which the held byte moves, and the clearing of the transmit-empty cause by an identification read.

// File: rtl/uart_shadow_pkg.sv
package uart_shadow_pkg;

  localparam int DW   = 8;
  localparam int NSRC = 7;

  // host register offsets (fixed by host software expectations)
  localparam logic [2:0] HA_DATA = 3'd0;
  localparam logic [2:0] HA_IER  = 3'd1;
  localparam logic [2:0] HA_IIR  = 3'd2;
  localparam logic [2:0] HA_LCR  = 3'd3;
  localparam logic [2:0] HA_MCR  = 3'd4;
  localparam logic [2:0] HA_LSR  = 3'd5;
  localparam logic [2:0] HA_MSR  = 3'd6;
  localparam logic [2:0] HA_SCR  = 3'd7;

  // notification flag positions
  localparam int NB_THR = 0;
  localparam int NB_DLL = 1;
  localparam int NB_DLM = 2;
  localparam int NB_FCR = 3;
  localparam int NB_LCR = 4;
  localparam int NB_MCR = 5;
  localparam int NB_RBR = 6;

  // identification codes
  localparam logic [3:0] ID_LINE = 4'h6;
  localparam logic [3:0] ID_RDA  = 4'h4;
  localparam logic [3:0] ID_TMO  = 4'hC;
  localparam logic [3:0] ID_THRE = 4'h2;
  localparam logic [3:0] ID_MDM  = 4'h0;
  localparam logic [3:0] ID_NONE = 4'h1;

  typedef struct packed {
    logic line;
    logic rda;
    logic tmo;
    logic thre;
    logic mdm;
  } irq_src_t;

  function automatic logic [3:0] rank_cause(input irq_src_t s);
    if (s.line)      return ID_LINE;
    else if (s.rda)  return ID_RDA;
    else if (s.tmo)  return ID_TMO;
    else if (s.thre) return ID_THRE;
    else if (s.mdm)  return ID_MDM;
    return ID_NONE;
  endfunction

  function automatic logic [7:0] line_view(input logic b7, input logic [4:0] low,
                                           input logic thr_full, input logic tsr_full);
    return {b7, ~thr_full & ~tsr_full, ~thr_full, low};
  endfunction

endpackage

// File: rtl/uart_shadow_host.sv
module uart_shadow_host
  import uart_shadow_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         rd,
  input  logic         wr,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rbr,
  input  logic [W-1:0] lsr,
  input  logic [W-1:0] msr,
  input  logic [W-1:0] iir,
  output logic [W-1:0] rdata,
  output logic [W-1:0] lcr,
  output logic [W-1:0] mcr,
  output logic [W-1:0] ier,
  output logic [W-1:0] dll,
  output logic [W-1:0] dlm,
  output logic [W-1:0] fcr,
  output logic [W-1:0] scr,
  output logic [W-1:0] thr,
  output logic         ev_thr_wr,
  output logic         ev_dll_wr,
  output logic         ev_dlm_wr,
  output logic         ev_fcr_wr,
  output logic         ev_lcr_wr,
  output logic         ev_mcr_wr,
  output logic         ev_rbr_rd,
  output logic         ev_iir_rd
);

  logic wr_s, rd_s, dlab, ier_we, scr_we;

  always_comb begin
    wr_s      = cs & wr;
    rd_s      = cs & rd;
    dlab      = lcr[W-1];
    ev_thr_wr = wr_s && addr == HA_DATA && !dlab;
    ev_dll_wr = wr_s && addr == HA_DATA &&  dlab;
    ev_dlm_wr = wr_s && addr == HA_IER  &&  dlab;
    ier_we    = wr_s && addr == HA_IER  && !dlab;
    ev_fcr_wr = wr_s && addr == HA_IIR;
    ev_lcr_wr = wr_s && addr == HA_LCR;
    ev_mcr_wr = wr_s && addr == HA_MCR;
    scr_we    = wr_s && addr == HA_SCR;
    ev_rbr_rd = rd_s && addr == HA_DATA && !dlab;
    ev_iir_rd = rd_s && addr == HA_IIR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr <= '0; mcr <= '0; ier <= '0; dll <= '0;
      dlm <= '0; fcr <= '0; scr <= '0; thr <= '0;
    end else begin
      if (ev_lcr_wr) lcr <= wdata;
      if (ev_mcr_wr) mcr <= wdata;
      if (ier_we)    ier <= wdata;
      if (ev_dll_wr) dll <= wdata;
      if (ev_dlm_wr) dlm <= wdata;
      if (ev_fcr_wr) fcr <= wdata;
      if (scr_we)    scr <= wdata;
      if (ev_thr_wr) thr <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      HA_DATA: rdata = dlab ? dll : rbr;
      HA_IER:  rdata = dlab ? dlm : ier;
      HA_IIR:  rdata = iir;
      HA_LCR:  rdata = lcr;
      HA_MCR:  rdata = mcr;
      HA_LSR:  rdata = lsr;
      HA_MSR:  rdata = msr;
      default: rdata = scr;
    endcase
  end

endmodule

// File: rtl/uart_shadow_tx.sv
module uart_shadow_tx #(
  parameter int W  = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_we,
  input  logic [W-1:0]  thr,
  input  logic          tsr_rd,
  input  logic [TW-1:0] rld,
  output logic          thr_full,
  output logic          tsr_full,
  output logic [W-1:0]  tsr_data,
  output logic [TW-1:0] dly_cnt,
  output logic          xfer
);

  logic dly_done;

  always_comb begin
    dly_done = (dly_cnt == '0);
    xfer     = thr_full & ~tsr_full & dly_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_full <= 1'b0;
      tsr_full <= 1'b0;
      tsr_data <= '0;
      dly_cnt  <= '0;
    end else begin
      thr_full <= thr_we | (thr_full & ~xfer);
      tsr_full <= xfer | (tsr_full & ~tsr_rd);
      if (xfer) tsr_data <= thr;
      if (xfer)           dly_cnt <= rld;
      else if (!dly_done) dly_cnt <= dly_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/uart_shadow_notify.sv
module uart_shadow_notify #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  input  logic         mask_we,
  input  logic [N:0]   mask_wd,
  output logic [N-1:0] flags,
  output logic [N:0]   mask,
  output logic         irq
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (clr)    flags[i] <= 1'b0;   // processor clear wins
      else if (evt[i]) flags[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wd;
  end

  assign irq = mask[N] & |(flags & mask[N-1:0]);

endmodule

// File: rtl/uart_shadow_iirgen.sv
module uart_shadow_iirgen
  import uart_shadow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] lsr_low,
  input  logic [3:0] msr_delta,
  input  logic [3:0] ier_en,
  input  logic       rx_tmo,
  input  logic       xfer,
  input  logic       thr_wr,
  input  logic       iir_rd,
  output logic [7:0] iir,
  output logic       pending
);

  logic     thre_pend;
  irq_src_t src;
  logic [3:0] code;

  always_comb begin
    src.line = ier_en[2] & |lsr_low[4:1];
    src.rda  = ier_en[0] & lsr_low[0];
    src.tmo  = ier_en[0] & rx_tmo;
    src.thre = ier_en[1] & thre_pend;
    src.mdm  = ier_en[3] & |msr_delta;
    code     = rank_cause(src);
    iir      = {4'b0, code};
    pending  = ~code[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        thre_pend <= 1'b0;
    else if (thr_wr)                   thre_pend <= 1'b0;
    else if (xfer)                     thre_pend <= 1'b1;
    else if (iir_rd && code == ID_THRE) thre_pend <= 1'b0;
  end

endmodule

// File: rtl/uart_host_shadow.sv
module uart_host_shadow
  import uart_shadow_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h_cs,
  input  logic       h_rd,
  input  logic       h_wr,
  input  logic [2:0] h_addr,
  input  logic [7:0] h_wdata,
  output logic [7:0] h_rdata,
  output logic       h_irq,
  output logic       h_irq_oe,
  input  logic       m_cs,
  input  logic       m_rd,
  input  logic       m_wr,
  input  logic [3:0] m_addr,
  input  logic [7:0] m_wdata,
  output logic [7:0] m_rdata,
  output logic       m_irq
);

  localparam int MW = NSRC + 1;

  // processor-side state
  logic [7:0]    rbr_q, msr_q;
  logic [4:0]    lsr_low;
  logic          lsr_b7, tmo_q;
  logic [TW-1:0] dly_rld;

  // host shadows
  logic [7:0] lcr, mcr, ier, dll, dlm, fcr, scr, thr, lsr_w, iir_w;
  logic ev_thr_wr, ev_dll_wr, ev_dlm_wr, ev_fcr_wr, ev_lcr_wr, ev_mcr_wr, ev_rbr_rd, ev_iir_rd;

  // transmit path
  logic          thr_full, tsr_full, xfer;
  logic [7:0]    tsr_data;
  logic [TW-1:0] dly_cnt;

  // notification
  logic [NSRC-1:0] evt, nflags;
  logic [MW-1:0]   nmask;

  // processor strobes
  logic m_we, m_re, stat_rd, tsr_rd, mask_we;

  always_comb begin
    m_we    = m_cs & m_wr;
    m_re    = m_cs & m_rd;
    stat_rd = m_re && m_addr == 4'd4;
    tsr_rd  = m_re && m_addr == 4'd3;
    mask_we = m_we && m_addr == 4'd5;
    lsr_w   = line_view(lsr_b7, lsr_low, thr_full, tsr_full);
  end

  always_comb begin
    evt         = '0;
    evt[NB_THR] = ev_thr_wr;
    evt[NB_DLL] = ev_dll_wr;
    evt[NB_DLM] = ev_dlm_wr;
    evt[NB_FCR] = ev_fcr_wr;
    evt[NB_LCR] = ev_lcr_wr;
    evt[NB_MCR] = ev_mcr_wr;
    evt[NB_RBR] = ev_rbr_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q <= '0; msr_q <= '0; lsr_low <= '0; lsr_b7 <= 1'b0;
      tmo_q <= 1'b0; dly_rld <= '0;
    end else if (m_we) begin
      unique case (m_addr)
        4'd0:  rbr_q <= m_wdata;
        4'd1:  begin lsr_b7 <= m_wdata[7]; lsr_low <= m_wdata[4:0]; end
        4'd2:  msr_q <= m_wdata;
        4'd6:  dly_rld <= TW'(m_wdata);
        4'd13: tmo_q <= m_wdata[0];
        default: ;
      endcase
    end
  end

  uart_shadow_host #(.W(8)) u_host (
    .clk(clk), .rst_n(rst_n), .cs(h_cs), .rd(h_rd), .wr(h_wr),
    .addr(h_addr), .wdata(h_wdata),
    .rbr(rbr_q), .lsr(lsr_w), .msr(msr_q), .iir(iir_w),
    .rdata(h_rdata), .lcr(lcr), .mcr(mcr), .ier(ier), .dll(dll), .dlm(dlm),
    .fcr(fcr), .scr(scr), .thr(thr),
    .ev_thr_wr(ev_thr_wr), .ev_dll_wr(ev_dll_wr), .ev_dlm_wr(ev_dlm_wr),
    .ev_fcr_wr(ev_fcr_wr), .ev_lcr_wr(ev_lcr_wr), .ev_mcr_wr(ev_mcr_wr),
    .ev_rbr_rd(ev_rbr_rd), .ev_iir_rd(ev_iir_rd)
  );

  uart_shadow_tx #(.W(8), .TW(TW)) u_tx (
    .clk(clk), .rst_n(rst_n), .thr_we(ev_thr_wr), .thr(thr), .tsr_rd(tsr_rd),
    .rld(dly_rld), .thr_full(thr_full), .tsr_full(tsr_full),
    .tsr_data(tsr_data), .dly_cnt(dly_cnt), .xfer(xfer)
  );

  uart_shadow_notify #(.N(NSRC)) u_notify (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(stat_rd),
    .mask_we(mask_we), .mask_wd(m_wdata[MW-1:0]),
    .flags(nflags), .mask(nmask), .irq(m_irq)
  );

  uart_shadow_iirgen u_iir (
    .clk(clk), .rst_n(rst_n), .lsr_low(lsr_low), .msr_delta(msr_q[3:0]),
    .ier_en(ier[3:0]), .rx_tmo(tmo_q), .xfer(xfer), .thr_wr(ev_thr_wr),
    .iir_rd(ev_iir_rd), .iir(iir_w), .pending(h_irq)
  );

  assign h_irq_oe = mcr[3];

  always_comb begin
    unique case (m_addr)
      4'd0:  m_rdata = rbr_q;
      4'd1:  m_rdata = lsr_w;
      4'd2:  m_rdata = msr_q;
      4'd3:  m_rdata = tsr_data;
      4'd4:  m_rdata = 8'(nflags);
      4'd5:  m_rdata = 8'(nmask);
      4'd6:  m_rdata = 8'(dly_rld);
      4'd7:  m_rdata = lcr;
      4'd8:  m_rdata = mcr;
      4'd9:  m_rdata = dll;
      4'd10: m_rdata = dlm;
      4'd11: m_rdata = fcr;
      4'd12: m_rdata = ier;
      4'd13: m_rdata = {7'b0, tmo_q};
      4'd14: m_rdata = scr;
      default: m_rdata = {6'b0, tsr_full, thr_full};
    endcase
  end

endmodule

// File: rtl/uart_shadow_chk.sv
module uart_shadow_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_cs,
  input logic          h_wr,
  input logic [2:0]    h_addr,
  input logic [7:0]    h_wdata,
  input logic          h_irq_oe,
  input logic [7:0]    h_iir,
  input logic          m_cs,
  input logic          m_rd,
  input logic [3:0]    m_addr,
  input logic          m_irq,
  input logic          tsr_full,
  input logic [TW-1:0] dly_cnt,
  input logic [TW-1:0] dly_rld,
  input logic          mask_global
);

  assert_oe_follows_mcr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cs && h_wr && h_addr == 3'd4) |=> (h_irq_oe == $past(h_wdata[3])));

  assert_status_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cs && m_rd && m_addr == 4'd4) |=> !m_irq);

  assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_global |-> !m_irq);

  assert_legal_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_iir[7:4] == 4'h0) && (h_iir[3:0] == 4'h6 || h_iir[3:0] == 4'h4 ||
     h_iir[3:0] == 4'hC || h_iir[3:0] == 4'h2 || h_iir[3:0] == 4'h0 ||
     h_iir[3:0] == 4'h1));

  assert_xfer_on_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsr_full) |-> $past(dly_cnt) == '0);

  assert_reload_on_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsr_full) |-> dly_cnt == $past(dly_rld));

  assert_countdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_cnt != '0) |=> dly_cnt == $past(dly_cnt) - 1'b1);

endmodule

bind uart_host_shadow uart_shadow_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_cs(h_cs), .h_wr(h_wr), .h_addr(h_addr),
  .h_wdata(h_wdata), .h_irq_oe(h_irq_oe), .h_iir(iir_w),
  .m_cs(m_cs), .m_rd(m_rd), .m_addr(m_addr), .m_irq(m_irq),
  .tsr_full(tsr_full), .dly_cnt(dly_cnt), .dly_rld(dly_rld),
  .mask_global(nmask[7])
);

// File: tb/uart_host_shadow_bench.sv
module uart_host_shadow_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_cs = 0, h_rd = 0, h_wr = 0;
  logic [2:0] h_addr = '0;
  logic [7:0] h_wdata = '0;
  logic [7:0] h_rdata;
  logic h_irq, h_irq_oe;
  logic m_cs = 0, m_rd = 0, m_wr = 0;
  logic [3:0] m_addr = '0;
  logic [7:0] m_wdata = '0;
  logic [7:0] m_rdata;
  logic m_irq;

  always #5 clk = ~clk;

  uart_host_shadow u_uart_host_shadow (
    .clk(clk), .rst_n(rst_n),
    .h_cs(h_cs), .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq(h_irq), .h_irq_oe(h_irq_oe),
    .m_cs(m_cs), .m_rd(m_rd), .m_wr(m_wr), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_irq(m_irq)
  );

  int nvec = 0;
  int nfail = 0;
  bit reported = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    h_cs = 1; h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_cs = 0; h_wr = 0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    h_cs = 1; h_rd = 1; h_addr = a;
    #1 d = h_rdata;
    @(negedge clk);
    h_cs = 0; h_rd = 0;
  endtask

  task automatic mpu_wr(input logic [3:0] a, input logic [7:0] d);
    m_cs = 1; m_wr = 1; m_addr = a; m_wdata = d;
    @(negedge clk);
    m_cs = 0; m_wr = 0;
  endtask

  task automatic mpu_rd(input logic [3:0] a, output logic [7:0] d);
    m_cs = 1; m_rd = 1; m_addr = a;
    #1 d = m_rdata;
    @(negedge clk);
    m_cs = 0; m_rd = 0;
  endtask

  // expected identification from the priority list
  function automatic logic [7:0] exp_iir(input logic [7:0] lsr, input logic [7:0] msr,
                                         input logic [7:0] ier, input logic tmo);
    logic [4:0] act;
    act = {ier[2] & (lsr[4:1] != 0), ier[0] & lsr[0], ier[0] & tmo, 1'b0,
           ier[3] & (msr[3:0] != 0)};
    casez (act)
      5'b1????: return 8'h06;
      5'b01???: return 8'h04;
      5'b001??: return 8'h0C;
      5'b0001?: return 8'h02;
      5'b00001: return 8'h00;
      default:  return 8'h01;
    endcase
  endfunction

  // which notification flag a host access raises
  function automatic logic [6:0] flag_of(input logic w, input logic [2:0] a, input logic dl);
    logic [6:0] f;
    f = '0;
    if (w) begin
      case (a)
        3'd0: if (dl) f[1] = 1; else f[0] = 1;
        3'd1: if (dl) f[2] = 1;
        3'd2: f[3] = 1;
        3'd3: f[4] = 1;
        3'd4: f[5] = 1;
        default: ;
      endcase
    end else if (a == 3'd0 && !dl) f[6] = 1;
    return f;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] r, lsr, msr, ier, mcr, mask;
    logic [7:0] m_lcr, m_mcr, m_ier, m_dll, m_dlm, m_fcr, m_scr;
    logic [6:0] eflags;
    logic tmo, dl;
    int seed;
    seed = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq_oe", {7'b0, h_irq_oe}, 8'h00);
    chk("R1 m_irq", {7'b0, m_irq}, 8'h00);
    host_rd(3'd2, r); chk("R1 iir", r, 8'h01);
    host_rd(3'd5, r); chk("R1 lsr", r, 8'h60);
    mpu_rd(4'd7, r);  chk("R1 lcr shadow", r, 8'h00);

    // R10 / R11 directed handoff with reload 5
    mpu_wr(4'd6, 8'd5);
    host_wr(3'd0, 8'hA5);
    host_rd(3'd5, r); chk("R10 lsr holding full", r, 8'h00);
    mpu_rd(4'd15, r); chk("R11 moved to shift", r, 8'h02);
    mpu_rd(4'd3, r);  chk("R11 shift byte", r, 8'hA5);
    host_rd(3'd5, r); chk("R10 lsr all empty", r, 8'h60);
    host_wr(3'd0, 8'h3C);
    mpu_rd(4'd15, r); chk("R10 held cnt1", r, 8'h01);
    mpu_rd(4'd15, r); chk("R10 held cnt0", r, 8'h01);
    mpu_rd(4'd15, r); chk("R10 moved after expiry", r, 8'h02);
    host_wr(3'd1, 8'h02);
    host_wr(3'd4, 8'h08);
    chk("R9 oe on", {7'b0, h_irq_oe}, 8'h01);
    chk("R9 irq thre", {7'b0, h_irq}, 8'h01);
    host_rd(3'd2, r); chk("R8 iir thre", r, 8'h02);
    host_rd(3'd2, r); chk("R8 thre cleared by read", r, 8'h01);
    mpu_rd(4'd3, r);  chk("R11 second byte", r, 8'h3C);
    mpu_rd(4'd4, r);  // drain flags

    // R2 directed divisor access
    host_wr(3'd3, 8'h83);
    host_wr(3'd0, 8'h12);
    host_wr(3'd1, 8'h34);
    host_rd(3'd0, r); chk("R2 dll host", r, 8'h12);
    host_wr(3'd3, 8'h03);
    host_rd(3'd1, r); chk("R2 ier untouched", r, 8'h02);
    mpu_rd(4'd9, r);  chk("R2 dll mpu", r, 8'h12);
    mpu_rd(4'd10, r); chk("R2 dlm mpu", r, 8'h34);
    mpu_rd(4'd15, r); chk("R2 no holding write", r, 8'h00);
    mpu_rd(4'd4, r);  chk("R3 flags dll dlm lcr", r, 8'h16);

    // R5 same-cycle set and clear
    mpu_wr(4'd5, 8'hFF);
    h_cs = 1; h_wr = 1; h_addr = 3'd2; h_wdata = 8'h01;
    m_cs = 1; m_rd = 1; m_addr = 4'd4;
    @(negedge clk);
    h_cs = 0; h_wr = 0; m_cs = 0; m_rd = 0;
    chk("R5 irq after clash", {7'b0, m_irq}, 8'h00);
    mpu_rd(4'd4, r); chk("R5 flag cleared", r, 8'h00);

    // R3 / R4 random host traffic
    m_lcr = 8'h03; m_mcr = 8'h08; m_ier = 8'h02; m_dll = 8'h12; m_dlm = 8'h34;
    m_fcr = 8'h01; m_scr = 8'h00; eflags = '0; mask = 8'hFF;
    for (int i = 0; i < 60; i++) begin
      logic [2:0] a;
      logic w;
      logic [7:0] d;
      if (i % 7 == 0) begin mask = 8'($urandom); mpu_wr(4'd5, mask); end
      a = 3'($urandom); w = 1'($urandom); d = 8'($urandom);
      dl = m_lcr[7];
      eflags |= flag_of(w, a, dl);
      if (w) begin
        host_wr(a, d);
        case (a)
          3'd0: if (dl) m_dll = d;
          3'd1: if (dl) m_dlm = d; else m_ier = d;
          3'd2: m_fcr = d;
          3'd3: m_lcr = d;
          3'd4: m_mcr = d;
          3'd7: m_scr = d;
          default: ;
        endcase
      end else begin
        host_rd(a, r);
        case (a)
          3'd0: chk("R2 addr0 read", r, dl ? m_dll : 8'h00);
          3'd1: chk("R2 addr1 read", r, dl ? m_dlm : m_ier);
          3'd3: chk("R1 lcr read", r, m_lcr);
          3'd4: chk("R9 mcr read", r, m_mcr);
          3'd6: chk("R7 msr read", r, 8'h00);
          3'd7: chk("R2 scr read", r, m_scr);
          default: ;
        endcase
      end
      chk("R4 m_irq", {7'b0, m_irq}, {7'b0, mask[7] & ((eflags & mask[6:0]) != 0)});
      chk("R9 oe", {7'b0, h_irq_oe}, {7'b0, m_mcr[3]});
      if (i % 3 == 2) begin
        mpu_rd(4'd4, r); chk("R3 flags", r, {1'b0, eflags});
        eflags = '0;
      end
    end
    mpu_rd(4'd7, r);  chk("R2 lcr shadow", r, m_lcr);
    mpu_rd(4'd11, r); chk("R3 fcr shadow", r, m_fcr);
    mpu_rd(4'd12, r); chk("R7 ier shadow", r, m_ier);
    mpu_rd(4'd14, r); chk("R2 scr shadow", r, m_scr);

    // drain the transmit path and clear any transmit-empty cause
    mpu_rd(4'd3, r); repeat (8) @(negedge clk);
    mpu_rd(4'd3, r); repeat (8) @(negedge clk);
    host_wr(3'd3, 8'h03);
    host_wr(3'd1, 8'h02);
    host_rd(3'd2, r);
    host_rd(3'd2, r); chk("R8 thre idle", r, 8'h01);
    mpu_rd(4'd4, r);

    // R6 / R7 random priority
    for (int i = 0; i < 50; i++) begin
      lsr = 8'($urandom); msr = 8'($urandom); tmo = 1'($urandom);
      ier = 8'($urandom); mcr = 8'($urandom);
      if (i % 5 == 0) lsr = 8'h00;
      if (i % 4 == 0) msr[3:0] = 4'h0;
      mpu_wr(4'd1, lsr); mpu_wr(4'd2, msr); mpu_wr(4'd13, {7'b0, tmo});
      host_wr(3'd1, ier); host_wr(3'd4, mcr);
      host_rd(3'd2, r); chk("R6 iir", r, exp_iir(lsr, msr, ier, tmo));
      chk("R9 irq", {7'b0, h_irq}, {7'b0, exp_iir(lsr, msr, ier, tmo) != 8'h01});
      chk("R9 oe", {7'b0, h_irq_oe}, {7'b0, mcr[3]});
      host_rd(3'd5, r); chk("R10 lsr view", r, {lsr[7], 2'b11, lsr[4:0]});
      host_rd(3'd6, r); chk("R7 msr view", r, msr);
    end

    // R6 / R7 directed corners
    mpu_wr(4'd1, 8'h1F); mpu_wr(4'd2, 8'h0F); mpu_wr(4'd13, 8'h01);
    host_wr(3'd1, 8'h0F);
    host_rd(3'd2, r); chk("R6 all on line first", r, 8'h06);
    host_wr(3'd1, 8'h09);
    host_rd(3'd2, r); chk("R6 rda over modem", r, 8'h04);
    mpu_wr(4'd1, 8'h00);
    host_rd(3'd2, r); chk("R6 timeout", r, 8'h0C);
    host_wr(3'd1, 8'h08);
    host_rd(3'd2, r); chk("R7 modem only", r, 8'h00);
    host_wr(3'd1, 8'h00);
    host_rd(3'd2, r); chk("R7 all disabled", r, 8'h01);

    report();
  end

endmodule